// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block turns the state of a UART's receive and transmit queues into interrupt information. Each cycle it forms a live status word from the two queue occupancy counts and two programmable trigger levels. It folds that word, and a set of single-cycle event pulses, into a sticky status register that holds each condition until software acknowledges it. A mask register gates the sticky bits onto one level-sensitive interrupt line.

Software reaches the block through a small synchronous write port and a combinational read port. Writes to the acknowledge register clear the bits written as one. The mask is never written directly. One register sets mask bits, another clears them, and writes to the mask address are dropped. The queues, the serial engine and the baud timing sit outside the block and supply the counts and the event pulses.

Top module: `uart_irq_status`

## Requirements
- R1: The live status word (read at address 4) has bit 0 = rx_count >= RX trigger, bit 1 = rx_count == 0, bit 2 = rx_count == 16, bit 3 = tx_count == 0, bit 4 = tx_count == 16, bit 13 = tx_count >= TX trigger, and every other bit 0. It follows the current inputs in the same cycle.
- R2: On each clock edge, any of live bits 0 to 4 that is high sets the same sticky bit. Live bit 13 sets sticky bit 10. Sticky bits stay set after the condition goes away, until software clears them.
- R3: Event pulses set sticky bits on the next edge: RX overflow bit 5, framing error bit 6, parity error bit 7, receive timeout bit 8, modem-status change bit 9, TX overflow bit 12.
- R4: Writing address 3 clears every sticky bit written as 1 and leaves the other bits as they are. Address 3 reads back the sticky register.
- R5: When a set condition and a clear write hit the same sticky bit in the same cycle, the bit ends up set.
- R6: Writing address 0 ORs the data into the mask. Writing address 1 clears the written bits from the mask. Writing address 2 leaves the mask unchanged. Address 2 reads the mask, and addresses 0 and 1 read 0.
- R7: The irq output is a register that equals the OR of (mask AND sticky) as they stood one edge earlier.
- R8: Reset (rst_n low) sets mask and sticky to 0 and irq to 0, and loads both trigger levels with 0x20. The RX trigger is read and written at address 5 and the TX trigger at address 6, 6 bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_count | input | 5 | Receive queue occupancy, 0 to 16 |
| tx_count | input | 5 | Transmit queue occupancy, 0 to 16 |
| ev_rx_ovr | input | 1 | Receive overflow pulse |
| ev_tx_ovr | input | 1 | Transmit overflow pulse |
| ev_frame | input | 1 | Framing error pulse |
| ev_parity | input | 1 | Parity error pulse |
| ev_timeout | input | 1 | Receive timeout pulse |
| ev_modem | input | 1 | Modem-status change pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| irq | output | 1 | Level interrupt output |

## Verification
A bad live-word comparator shows up as a wrong read at address 4 in the same cycle as the count change. The sweeps over every occupancy and a spread of trigger values expose it. A wrong sticky update, such as a lost event, a clear that wins over a set, or the TX-trigger bit landing in the wrong position, shows at address 3 one edge after the stimulus. A mask or irq fault shows at address 2 one edge after the write, or on irq exactly two edges after the event, and never one.

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
  parameter int TRIG_W     = 6,
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 3,
  parameter logic [TRIG_W-1:0] TRIG_RST = 6'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic              ev_rx_ovr,
  input  logic              ev_tx_ovr,
  input  logic              ev_frame,
  input  logic              ev_parity,
  input  logic              ev_timeout,
  input  logic              ev_modem,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_ENA    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DIS    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STICKY = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_LIVE   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_RTRIG  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_TTRIG  = ADDR_W'(6);

  localparam int LV_TX_TRIG = 13;
  localparam int SK_TX_TRIG = 10;
  localparam int SK_RX_OVR  = 5;
  localparam int SK_FRAME   = 6;
  localparam int SK_PARITY  = 7;
  localparam int SK_TMO     = 8;
  localparam int SK_MODEM   = 9;
  localparam int SK_TX_OVR  = 12;

  logic [TRIG_W-1:0] rx_trig_q, tx_trig_q;
  logic [DATA_W-1:0] mask_q, sticky_q, live, set_vec, clr_vec;

  wire wr_ena    = reg_wr && (reg_addr == A_ENA);
  wire wr_dis    = reg_wr && (reg_addr == A_DIS);
  wire wr_sticky = reg_wr && (reg_addr == A_STICKY);
  wire wr_rtrig  = reg_wr && (reg_addr == A_RTRIG);
  wire wr_ttrig  = reg_wr && (reg_addr == A_TTRIG);

  always_comb begin
    live = '0;
    live[0] = 32'(rx_count) >= 32'(rx_trig_q);
    live[1] = rx_count == '0;
    live[2] = 32'(rx_count) == FIFO_DEPTH;
    live[3] = tx_count == '0;
    live[4] = 32'(tx_count) == FIFO_DEPTH;
    live[LV_TX_TRIG] = 32'(tx_count) >= 32'(tx_trig_q);
  end

  always_comb begin
    set_vec = '0;
    set_vec[4:0]       = live[4:0];
    set_vec[SK_TX_TRIG] = live[LV_TX_TRIG];
    set_vec[SK_RX_OVR] = ev_rx_ovr;
    set_vec[SK_FRAME]  = ev_frame;
    set_vec[SK_PARITY] = ev_parity;
    set_vec[SK_TMO]    = ev_timeout;
    set_vec[SK_MODEM]  = ev_modem;
    set_vec[SK_TX_OVR] = ev_tx_ovr;
  end

  assign clr_vec = wr_sticky ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q  <= '0;
      mask_q    <= '0;
      rx_trig_q <= TRIG_RST;
      tx_trig_q <= TRIG_RST;
      irq       <= 1'b0;
    end else begin
      sticky_q <= (sticky_q & ~clr_vec) | set_vec;
      if (wr_ena)   mask_q <= mask_q | reg_wdata;
      else if (wr_dis) mask_q <= mask_q & ~reg_wdata;
      if (wr_rtrig) rx_trig_q <= reg_wdata[TRIG_W-1:0];
      if (wr_ttrig) tx_trig_q <= reg_wdata[TRIG_W-1:0];
      irq <= |(mask_q & sticky_q);
    end
  end

  always_comb begin
    case (reg_addr)
      A_MASK:   reg_rdata = mask_q;
      A_STICKY: reg_rdata = sticky_q;
      A_LIVE:   reg_rdata = live;
      A_RTRIG:  reg_rdata = DATA_W'(rx_trig_q);
      A_TTRIG:  reg_rdata = DATA_W'(tx_trig_q);
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk #(
  parameter int CNT_W  = 5,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  rx_count,
  input logic              ev_frame,
  input logic              ev_parity,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] sticky_q,
  input logic [DATA_W-1:0] mask_q,
  input logic              irq
);

  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == ADDR_W'(3)) |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q))); // R2

  AST_RX_EMPTY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |=> sticky_q[1]); // R2

  AST_FRAME_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame |=> sticky_q[6]); // R3

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_parity && reg_wr && reg_addr == ADDR_W'(3) && reg_wdata[7]) |=> sticky_q[7]); // R5

  AST_MASK_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(2)) |=> $stable(mask_q)); // R6

  AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |($past(mask_q) & $past(sticky_q)))); // R7

endmodule

bind uart_irq_status uart_irq_status_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .ev_frame(ev_frame), .ev_parity(ev_parity),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .sticky_q(sticky_q), .mask_q(mask_q), .irq(irq)
);

// File: tb/uart_irq_status_bench.sv
module uart_irq_status_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic [4:0] rx_count = 0, tx_count = 0;
  logic [5:0] ev = 0;
  logic reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;
  int ev_pos [6] = '{5, 12, 6, 7, 8, 9};

  always #2.5 clk = ~clk;

  uart_irq_status u_uart_irq_status (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
    .ev_rx_ovr(ev[0]), .ev_tx_ovr(ev[1]), .ev_frame(ev[2]), .ev_parity(ev[3]),
    .ev_timeout(ev[4]), .ev_modem(ev[5]),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [15:0] exp_live(int rx, int tx, int rt, int tt);
    logic [15:0] v = 0;
    v[0] = rx >= rt; v[1] = rx == 0; v[2] = rx == 16;
    v[3] = tx == 0;  v[4] = tx == 16; v[13] = tx >= tt;
    return v;
  endfunction

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] d;
    int trigs [8] = '{0, 1, 5, 8, 16, 17, 32, 63};
    repeat (3) @(negedge clk);
    rd(3'd2, d); check("R8 mask reset", d, 16'h0);
    rd(3'd3, d); check("R8 sticky reset", d, 16'h0);
    rd(3'd5, d); check("R8 rx trigger reset", d, 16'h20);
    rd(3'd6, d); check("R8 tx trigger reset", d, 16'h20);
    check("R8 irq reset", {15'h0, irq}, 16'h0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    rd(3'd3, d); check("R2 empty flags latched after reset", d, 16'h000A);
    rd(3'd4, d); check("R1 live after reset", d, 16'h000A);

    // R1 sweep over RX count and trigger
    tx_count = 5;
    foreach (trigs[i]) begin
      wr(3'd5, 16'(trigs[i]));
      for (int c = 0; c <= 16; c++) begin
        @(negedge clk); rx_count = 5'(c);
        rd(3'd4, d); check("R1 rx sweep", d, exp_live(c, 5, trigs[i], 32));
      end
    end
    wr(3'd5, 16'h20);
    rx_count = 5;
    foreach (trigs[i]) begin
      wr(3'd6, 16'(trigs[i]));
      rd(3'd6, d); check("R8 tx trigger readback", d, 16'(trigs[i]));
      for (int c = 0; c <= 16; c++) begin
        @(negedge clk); tx_count = 5'(c);
        rd(3'd4, d); check("R1 tx sweep", d, exp_live(5, c, 32, trigs[i]));
      end
    end
    @(negedge clk); tx_count = 5;
    wr(3'd6, 16'h20);

    // R4 clear all
    wr(3'd3, 16'hFFFF);
    rd(3'd3, d); check("R4 clear all", d, 16'h0);

    // R3 each event
    foreach (ev_pos[i]) begin
      @(negedge clk); ev[i] = 1;
      @(negedge clk); ev[i] = 0;
      rd(3'd3, d); check("R3 event sets bit", d, 16'(1 << ev_pos[i]));
      repeat (2) @(negedge clk);
      rd(3'd3, d); check("R3 event bit holds", d, 16'(1 << ev_pos[i]));
      wr(3'd3, 16'(1 << ev_pos[i]));
      rd(3'd3, d); check("R4 event bit cleared", d, 16'h0);
    end

    // R2 sticky hold after condition goes away, TX trigger at bit 10
    @(negedge clk); rx_count = 16;
    @(negedge clk); rx_count = 5;
    repeat (3) @(negedge clk);
    rd(3'd3, d); check("R2 rx full held", d, 16'h0004);
    wr(3'd6, 16'd3);
    @(negedge clk); tx_count = 16;
    @(negedge clk); tx_count = 5;
    rd(3'd3, d); check("R2 tx full and tx trigger at bit 10", d, 16'h0414);
    wr(3'd6, 16'h20);
    wr(3'd3, 16'h0010);
    rd(3'd3, d); check("R4 partial clear", d, 16'h0404);
    wr(3'd3, 16'hFFFF);
    rd(3'd3, d); check("R4 clear rest", d, 16'h0);

    // R5 set wins over clear in the same cycle
    @(negedge clk); ev[2] = 1;
    @(negedge clk); ev[2] = 0; ev[3] = 1;
    reg_wr = 1; reg_addr = 3'd3; reg_wdata = 16'h00C0;
    @(negedge clk); ev[3] = 0; reg_wr = 0;
    rd(3'd3, d); check("R5 set beats clear", d, 16'h0080);
    wr(3'd3, 16'hFFFF);

    // R6 mask access
    wr(3'd0, 16'h0041); rd(3'd2, d); check("R6 enable sets", d, 16'h0041);
    wr(3'd0, 16'h0100); rd(3'd2, d); check("R6 enable ORs", d, 16'h0141);
    wr(3'd1, 16'h0001); rd(3'd2, d); check("R6 disable clears", d, 16'h0140);
    wr(3'd2, 16'hFFFF); rd(3'd2, d); check("R6 mask write ignored", d, 16'h0140);
    rd(3'd0, d); check("R6 enable reads zero", d, 16'h0);
    rd(3'd1, d); check("R6 disable reads zero", d, 16'h0);

    // R7 irq latency
    check("R7 irq idle", {15'h0, irq}, 16'h0);
    @(negedge clk); ev[0] = 1;
    @(negedge clk); ev[0] = 0;
    @(negedge clk);
    check("R7 unmasked event no irq", {15'h0, irq}, 16'h0);
    wr(3'd3, 16'hFFFF);
    @(negedge clk); ev[2] = 1;
    @(negedge clk); ev[2] = 0;
    check("R7 irq not yet one edge after event", {15'h0, irq}, 16'h0);
    @(negedge clk);
    check("R7 irq two edges after event", {15'h0, irq}, 16'h1);
    wr(3'd1, 16'h0040);
    check("R7 irq held one edge after disable", {15'h0, irq}, 16'h1);
    @(negedge clk);
    check("R7 irq drops after disable", {15'h0, irq}, 16'h0);
    wr(3'd0, 16'h0040);
    @(negedge clk);
    check("R7 irq back after enable", {15'h0, irq}, 16'h1);
    wr(3'd3, 16'h0040);
    @(negedge clk);
    check("R7 irq drops after clear", {15'h0, irq}, 16'h0);

    summary();
  end
endmodule